// File: doc/BRIEF.md
# Three-Leg Shoot-Through Interlock

This block sits between a motor controller and the gate drivers of a three-phase inverter bridge. Each leg of the bridge has an upper-arm command and a lower-arm command, both active-low, and the block turns them into an upper and a lower gate enable for that leg. Its single job is to make sure the two switches of one leg are never enabled together, while still forwarding legitimate commands with a short, fixed delay.

Each leg keeps its own arbitration state. The arm whose request reaches the leg first is granted. A request for the opposite arm is held back for as long as the granted arm keeps asking. The held-back request is remembered, and it is granted on the same clock edge that the winner lets go, so no cycle is wasted. If both arms ask in the very same sampled cycle on a free leg, neither is granted until one of them withdraws. The block adds no dead time, since the controller already provides it, and it raises no fault when it blocks something. A separate gate-kill input forces every lower-arm enable low without losing the arbitration state. Commands cross into the clock domain through a two-flop synchronizer.

Top module: `gate_interlock`

## Requirements
- R1: A command pin at logic 0 is an ON request and at logic 1 is an OFF request; with only the upper pin of a free leg at 0 the upper enable goes to 1, with only the lower pin at 0 the lower enable goes to 1.
- R2: The upper and lower enables of the same leg are never 1 in the same cycle.
- R3: While one arm of a leg is enabled and its pin stays at 0, a 0 on the opposite arm's pin leaves that opposite enable at 0 and the granted enable at 1.
- R4: When the two pins of a free leg go to 0 in different cycles, the one that went to 0 first is granted, whichever arm it is.
- R5: A blocked request whose pin is still 0 is granted on the same clock edge that removes the winner's enable, with no idle cycle and no overlap.
- R6: When both pins of a free leg go to 0 in the same sampled cycle, both enables stay 0 until one pin returns to 1; the arm still at 0 is then granted.
- R7: An enable changes on the third rising clock edge after its pin changes (two synchronizer stages plus one state register), well inside ten cycles; at the second edge it has not yet changed.
- R8: The three legs (index 0, 1, 2 of each bus) are arbitrated independently; activity on one leg never changes another leg's enables.
- R9: While gate_kill is 1 every lower enable is 0 at once (combinational); the leg keeps its grant, so the upper arm of a leg held by the lower arm stays blocked, and the lower enable returns when gate_kill goes back to 0 if its pin is still 0.
- R10: Reset is synchronous and active-low; during and right after reset all enables are 0 and every leg is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd_n | input | NUM_LEGS | Upper-arm commands, active-low, one bit per leg |
| lo_cmd_n | input | NUM_LEGS | Lower-arm commands, active-low, one bit per leg |
| gate_kill | input | 1 | Forces all lower-arm enables to 0 while high |
| hi_gate_en | output | NUM_LEGS | Upper-arm gate enables, active-high |
| lo_gate_en | output | NUM_LEGS | Lower-arm gate enables, active-high |

## Verification
The hardest situation to reach is a leg sitting in its tie state, where both requests landed in the same synchronized cycle and nothing is granted; from the ports it only arises when both pins fall on the same clock interval, so the bench drives both pins of one leg on the same falling edge and then releases one of them to see the survivor granted. The gate-kill case is also subtle, because the stored grant is invisible while the lower enable is forced low; the bench reaches it by requesting the upper arm during the kill and checking that it stays blocked, then lifting the kill and releasing the lower pin to watch the remembered handover.

// File: rtl/ilk_pkg.sv
// Package: shared types for the shoot-through interlock.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ilk_pkg;

    // Per-leg arbitration state.
    typedef enum logic [1:0] {
        LEG_FREE = 2'd0,   // neither arm granted, no tie pending
        LEG_HI   = 2'd1,   // upper arm owns the leg
        LEG_LO   = 2'd2,   // lower arm owns the leg
        LEG_TIE  = 2'd3    // both arrived together, waiting for one to drop
    } leg_state_t;

endpackage

// File: rtl/ilk_sync.sv
// Module: ilk_sync
// Multi-stage flop synchronizer for a bus of independent level signals.
// Assumes each bit is a slow level (commands change far slower than clk),
// so bits need no mutual coherence. Reset value is a parameter so that
// active-low command pins reset to their inactive level.
module ilk_sync #(
    parameter int          WIDTH   = 6,
    parameter int          STAGES  = 2,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {WIDTH{RST_LVL}};
            end
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_sync = stage_q[LAST];

endmodule

// File: rtl/ilk_leg.sv
// Module: ilk_leg
// First-come arbiter for one half-bridge leg. Grants the arm whose
// synchronized request arrives first, holds the other off, and hands the
// leg to the waiting arm on the very edge the winner releases. A same-cycle
// double request parks the leg until one side withdraws.
// Assumes requests are already synchronized and active-high.
module ilk_leg
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    input  logic kill_lo,
    output logic hi_en,
    output logic lo_en
);

    leg_state_t state_q;
    leg_state_t state_d;

    // Next-state arbitration: first arrival wins, loser waits.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_FREE: begin
                if (req_hi && req_lo)  state_d = LEG_TIE;
                else if (req_hi)       state_d = LEG_HI;
                else if (req_lo)       state_d = LEG_LO;
            end
            LEG_HI: begin
                if (!req_hi) state_d = req_lo ? LEG_LO : LEG_FREE;
            end
            LEG_LO: begin
                if (!req_lo) state_d = req_hi ? LEG_HI : LEG_FREE;
            end
            LEG_TIE: begin
                if (!req_hi && !req_lo) state_d = LEG_FREE;
                else if (!req_lo)       state_d = LEG_HI;
                else if (!req_hi)       state_d = LEG_LO;
            end
            default: state_d = LEG_FREE;
        endcase
    end

    // Arbitration state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LEG_FREE;
        else        state_q <= state_d;
    end

    // Gate decode; the kill masks only the lower output, not the state.
    assign hi_en = (state_q == LEG_HI);
    assign lo_en = (state_q == LEG_LO) && !kill_lo;

    // R3: a granted upper arm keeps the leg while it still asks.
    a_r3_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_HI && req_hi) |=> (state_q == LEG_HI));

    // R3: a granted lower arm keeps the leg while it still asks.
    a_r3_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_LO && req_lo) |=> (state_q == LEG_LO));

    // R5: release of the upper arm hands the leg straight to a waiting lower arm.
    a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_HI && !req_hi && req_lo) |=> (state_q == LEG_LO));

    // R6: a tie stays parked while both sides keep asking.
    a_r6_tie_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_TIE && req_hi && req_lo) |=> (hi_en == 1'b0 && state_q == LEG_TIE));

    // R4: a lone upper request on a free leg is granted next cycle.
    a_r4_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_FREE && req_hi && !req_lo) |=> hi_en);

    // R9: the kill does not disturb a held lower grant.
    a_r9_kill_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_lo && state_q == LEG_LO && req_lo) |=> (state_q == LEG_LO && !hi_en));

endmodule

// File: rtl/gate_interlock.sv
// Module: gate_interlock
// Three-phase (NUM_LEGS) shoot-through interlock. Synchronizes the
// active-low arm commands, then runs one independent first-come arbiter
// per leg. Adds no dead time and reports no faults.
// Assumes the controller supplies dead time and commands are levels.
module gate_interlock #(
    parameter int NUM_LEGS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] hi_cmd_n,
    input  logic [NUM_LEGS-1:0] lo_cmd_n,
    input  logic                gate_kill,
    output logic [NUM_LEGS-1:0] hi_gate_en,
    output logic [NUM_LEGS-1:0] lo_gate_en
);

    localparam int SYNC_W = 2 * NUM_LEGS;

    logic [SYNC_W-1:0]   cmd_sync_n;
    logic [NUM_LEGS-1:0] req_hi;
    logic [NUM_LEGS-1:0] req_lo;

    // Bring both command buses into the clock domain together.
    ilk_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({lo_cmd_n, hi_cmd_n}),
        .q_sync  (cmd_sync_n)
    );

    // Convert synchronized active-low commands to active-high requests.
    assign req_hi = ~cmd_sync_n[NUM_LEGS-1:0];
    assign req_lo = ~cmd_sync_n[SYNC_W-1:NUM_LEGS];

    // One independent arbiter per leg.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        ilk_leg u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (req_hi[g]),
            .req_lo  (req_lo[g]),
            .kill_lo (gate_kill),
            .hi_en   (hi_gate_en[g]),
            .lo_en   (lo_gate_en[g])
        );

        // R2: the two switches of one leg are never enabled together.
        a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_gate_en[g] && lo_gate_en[g]));

        // R10: enables are low in the first cycle after reset is released.
        a_r10_reset_low: assert property (@(posedge clk)
            !rst_n |=> (!hi_gate_en[g] && !lo_gate_en[g]));
    end

endmodule

// File: tb/sim_gate_interlock.sv
module sim_gate_interlock;

    localparam int CLK_P    = 10;
    localparam int N        = 3;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hi_n = '1;
    logic [N-1:0] lo_n = '1;
    logic         kill = 1'b0;
    logic [N-1:0] hi_en;
    logic [N-1:0] lo_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_P/2) clk = ~clk;

    gate_interlock #(.NUM_LEGS(N), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_cmd_n   (hi_n),
        .lo_cmd_n   (lo_n),
        .gate_kill  (kill),
        .hi_gate_en (hi_en),
        .lo_gate_en (lo_en)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] exp_hi,
                         input logic [N-1:0] exp_lo);
        n_chk++;
        if (hi_en !== exp_hi || lo_en !== exp_lo) begin
            n_bad++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                     req, hi_en, lo_en, exp_hi, exp_lo);
        end
    endtask

    task automatic quiet();
        hi_n = '1; lo_n = '1; kill = 1'b0;
        step(4);
    endtask

    // R10: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        hi_n = 3'b110;
        step(4);
        check("R10 in reset", 3'b000, 3'b000);
        hi_n = '1;
        rst_n = 1'b1;
        step(4);
        check("R10 after reset", 3'b000, 3'b000);
    endtask

    // R1, R7: basic grant and exact latency.
    task automatic t_basic();
        hi_n = 3'b110;
        step(2);
        check("R7 not yet at second edge", 3'b000, 3'b000);
        step(1);
        check("R1 R7 upper granted at third edge", 3'b001, 3'b000);
        hi_n = '1;
        step(3);
        check("R1 upper released", 3'b000, 3'b000);
        lo_n = 3'b110;
        step(3);
        check("R1 lower granted", 3'b000, 3'b001);
        quiet();
    endtask

    // R3, R5: block while held, then seamless handover.
    task automatic t_block_handover();
        hi_n = 3'b110;
        step(4);
        lo_n = 3'b110;
        step(5);
        check("R3 lower blocked while upper held", 3'b001, 3'b000);
        hi_n = '1;
        step(2);
        check("R5 winner still on before third edge", 3'b001, 3'b000);
        step(1);
        check("R5 lower granted on release edge", 3'b000, 3'b001);
        quiet();
        check("R3 leg free after both release", 3'b000, 3'b000);
    endtask

    // R4: first arrival wins when the lower arm comes first.
    task automatic t_first_wins();
        lo_n = 3'b101;
        step(2);
        hi_n = 3'b101;
        step(5);
        check("R4 earlier lower wins", 3'b000, 3'b010);
        lo_n = '1;
        step(3);
        check("R4 R5 later upper admitted", 3'b010, 3'b000);
        quiet();
    endtask

    // R6: same-cycle arrival parks the leg.
    task automatic t_tie();
        hi_n = 3'b011;
        lo_n = 3'b011;
        step(6);
        check("R6 tie grants nothing", 3'b000, 3'b000);
        hi_n = '1;
        step(3);
        check("R6 survivor granted", 3'b000, 3'b100);
        quiet();
    endtask

    // R8: legs do not interfere.
    task automatic t_indep();
        hi_n = 3'b110;
        lo_n = 3'b101;
        step(4);
        check("R8 two legs granted separately", 3'b001, 3'b010);
        hi_n = 3'b010;
        lo_n = 3'b001;
        step(6);
        check("R8 tie on leg 2 leaves others", 3'b001, 3'b010);
        hi_n = 3'b111;
        step(3);
        check("R8 leg 0 release only touches leg 0 and 2", 3'b000, 3'b110);
        quiet();
    endtask

    // R9: kill masks lower enables but keeps the grant.
    task automatic t_kill();
        lo_n = 3'b101;
        step(4);
        check("R9 lower granted before kill", 3'b000, 3'b010);
        kill = 1'b1;
        step(1);
        check("R9 kill forces lower low", 3'b000, 3'b000);
        hi_n = 3'b101;
        step(5);
        check("R9 upper still blocked during kill", 3'b000, 3'b000);
        kill = 1'b0;
        step(1);
        check("R9 lower restored after kill", 3'b000, 3'b010);
        lo_n = '1;
        step(3);
        check("R9 R5 handover after kill", 3'b010, 3'b000);
        quiet();
    endtask

    initial begin
        step(1);
        t_reset();
        t_basic();
        t_block_handover();
        t_first_wins();
        t_tie();
        t_indep();
        t_kill();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule